// File: doc/BRIEF.md
# SDRAM Power-Up Initialization Sequencer

This block sits on the controller side of a two-bank synchronous DRAM and takes the memory from power-on to a usable idle state. After reset it holds the clock enable high, both byte-mask lines high and a no-operation command on the bus for a programmable start-up interval. It then issues, in a fixed order, one precharge of all banks, a programmable number of auto-refresh commands and a single mode register load. Between these commands it waits programmable recovery intervals and drives no-operation on every idle cycle. Once the mode register has settled, it raises a ready flag that stays high until the next reset.

All delays are module parameters given in clock cycles, worked out by the integrator from the clock frequency. For example, the 500 µs start-up hold at 250 MHz is 125000 cycles. The mode register word comes from four field parameters. The block is used once after reset: normal access traffic and periodic refresh are handed to other logic after `ready` rises. Command pins are registered, so every pin changes one cycle after the internal state that selects it.

Top module: `sdram_init_seq`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, the next cycle shows the NOP command (`cs_n`,`ras_n`,`cas_n`,`we_n` = 0,1,1,1), `ready` low, `cke` high, `dqm` = 2'b11, `ba` low and `addr` zero.
- R2: The first non-NOP command after reset release is precharge-all (0,0,1,0) with `addr[8]` = 1 and `ba` = 0. It appears exactly WAIT_CYCLES cycles after the cycle in which reset is released, and every earlier cycle carries NOP.
- R3: The first auto-refresh (0,0,0,1) appears exactly TRP_CYCLES cycles after the precharge-all.
- R4: Exactly REFRESH_COUNT auto-refresh commands are issued (REFRESH_COUNT is at least 8), each TRC_CYCLES cycles after the one before.
- R5: The mode register load (0,0,0,0) follows the last auto-refresh by exactly TRC_CYCLES cycles. It drives `ba` = 0 and `addr` = BURST_LEN_CODE + 8·BURST_INTERLEAVE + 16·CAS_LAT_CODE + 128·OP_MODE_CODE, which puts the burst length in `addr[2:0]`, the burst type in `addr[3]`, the CAS latency in `addr[6:4]` and the operating mode in `addr[8:7]`.
- R6: `ready` is low until exactly TRSC_CYCLES cycles after the mode register load. It then goes high and stays high with NOP on the bus until reset.
- R7: `cke` stays high and `dqm` stays 2'b11 on every cycle. Every cycle that is not one of the commands above carries NOP, and only one command is ever issued per cycle.
- R8: A reset asserted at any point of the sequence, including mid-wait and mid-refresh, aborts it, and the full sequence restarts from the start-up wait after release.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Memory clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cke | output | 1 | Clock enable to the memory |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| dqm | output | 2 | Upper/lower byte masks, held high |
| ba | output | 1 | Bank select |
| addr | output | 9 | Address lines; precharge-all flag and mode word |
| ready | output | 1 | Initialization complete |

## Verification
Two decisions fall in the same cycle: the expiry of the refresh-recovery timer and the test of whether the refresh budget is spent. Together they choose between one more auto-refresh and the mode register load. A small configuration with a refresh count of nine and short gaps is run to completion. The bench counts refreshes and measures every gap arithmetically, so an off-by-one in either counter shows up as a wrong refresh total or a wrong gap before the mode load. Reset is also asserted in the same cycles as the start-up timer and the refresh loop are running, and the bench checks that the sequence restarts cleanly with the full wait.

// File: rtl/sdram_init_pkg.sv
// Package: shared command codes, sequencer phases and the mode word helper.
// Assumes the command bus order {cs_n, ras_n, cas_n, we_n}.
package sdram_init_pkg;

    typedef enum logic [3:0] {
        CMD_NOP = 4'b0111,
        CMD_PRE = 4'b0010,
        CMD_REF = 4'b0001,
        CMD_MRS = 4'b0000
    } cmd_t;

    typedef enum logic [2:0] {
        PH_HOLD,
        PH_PRE,
        PH_PRE_GAP,
        PH_REF,
        PH_REF_GAP,
        PH_MRS,
        PH_MRS_GAP,
        PH_READY
    } phase_t;

    // Packs the four mode fields into the nine-bit address word.
    function automatic logic [8:0] pack_mode(input logic [2:0] bl, input logic bt,
                                             input logic [2:0] cl, input logic [1:0] op);
        return {op, cl, bt, bl};
    endfunction

    // Larger of two integers, used to size counters.
    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sdram_init_timer.sv
// Module: down-counting interval timer.
// Loading value V makes 'expired' true after V-1 further cycles; it then
// holds at one. Assumes every loaded or reset value is at least 2.
module sdram_init_timer #(
    parameter int WIDTH   = 17,
    parameter int RST_VAL = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [WIDTH-1:0] load_val,
    output logic             expired
);
    logic [WIDTH-1:0] count_q;

    // Counter: reset to the start-up value, reload on request, else count down to one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_q <= WIDTH'(RST_VAL);
        end else if (load) begin
            count_q <= load_val;
        end else if (count_q > WIDTH'(1)) begin
            count_q <= count_q - WIDTH'(1);
        end
    end

    // Expiry flag: the current interval ends this cycle.
    always_comb expired = (count_q <= WIDTH'(1));

endmodule

// File: rtl/sdram_init_ctrl.sv
// Module: phase machine of the start-up sequence.
// Selects one command per cycle (NOP when idle), reloads the timer on each
// command and counts the refreshes still owed. Assumes gaps of two or more.
module sdram_init_ctrl
    import sdram_init_pkg::*;
#(
    parameter int TW            = 17,
    parameter int CW            = 5,
    parameter int TRP_CYCLES    = 8,
    parameter int TRC_CYCLES    = 23,
    parameter int TRSC_CYCLES   = 2,
    parameter int REFRESH_COUNT = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          expired,
    output logic          tmr_load,
    output logic [TW-1:0] tmr_val,
    output cmd_t          cmd_sel,
    output logic          done
);
    phase_t        phase_q, phase_d;
    logic [CW-1:0] refs_left_q;

    // Next phase: command phases last one cycle, gap phases wait for the timer.
    always_comb begin
        phase_d = phase_q;
        unique case (phase_q)
            PH_HOLD:    if (expired) phase_d = PH_PRE;
            PH_PRE:     phase_d = PH_PRE_GAP;
            PH_PRE_GAP: if (expired) phase_d = PH_REF;
            PH_REF:     phase_d = PH_REF_GAP;
            PH_REF_GAP: if (expired) phase_d = (refs_left_q == '0) ? PH_MRS : PH_REF;
            PH_MRS:     phase_d = PH_MRS_GAP;
            PH_MRS_GAP: if (expired) phase_d = PH_READY;
            default:    phase_d = PH_READY;
        endcase
    end

    // Timer reload: each command arms the gap that must follow it.
    always_comb begin
        tmr_load = 1'b1;
        unique case (phase_q)
            PH_PRE:  tmr_val = TW'(TRP_CYCLES - 1);
            PH_REF:  tmr_val = TW'(TRC_CYCLES - 1);
            PH_MRS:  tmr_val = TW'(TRSC_CYCLES - 1);
            default: begin
                tmr_load = 1'b0;
                tmr_val  = '0;
            end
        endcase
    end

    // Command select: only the one-cycle command phases leave NOP.
    always_comb begin
        unique case (phase_q)
            PH_PRE:  cmd_sel = CMD_PRE;
            PH_REF:  cmd_sel = CMD_REF;
            PH_MRS:  cmd_sel = CMD_MRS;
            default: cmd_sel = CMD_NOP;
        endcase
    end

    // Completion flag for the output stage.
    always_comb done = (phase_q == PH_READY);

    // Phase register.
    always_ff @(posedge clk) begin
        if (!rst_n) phase_q <= PH_HOLD;
        else        phase_q <= phase_d;
    end

    // Refresh budget: set at precharge, one less per refresh issued.
    always_ff @(posedge clk) begin
        if (!rst_n)                  refs_left_q <= '0;
        else if (phase_q == PH_PRE)  refs_left_q <= CW'(REFRESH_COUNT);
        else if (phase_q == PH_REF)  refs_left_q <= refs_left_q - CW'(1);
    end

endmodule

// File: rtl/sdram_cmd_drv.sv
// Module: registered pin stage.
// Turns the selected command into pin levels, bank and address values, so
// every output comes straight from a flop. Holds clock enable and masks high.
module sdram_cmd_drv
    import sdram_init_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  cmd_t       cmd_sel,
    input  logic       done,
    input  logic [8:0] mode_word,
    output logic       cke,
    output logic       cs_n,
    output logic       ras_n,
    output logic       cas_n,
    output logic       we_n,
    output logic [1:0] dqm,
    output logic       ba,
    output logic [8:0] addr,
    output logic       ready
);
    logic [8:0] addr_d;

    // Address value for the chosen command.
    always_comb begin
        unique case (cmd_sel)
            CMD_PRE: addr_d = 9'h100;
            CMD_MRS: addr_d = mode_word;
            default: addr_d = '0;
        endcase
    end

    // Output flops: NOP, masks high and not ready while in reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            {cs_n, ras_n, cas_n, we_n} <= CMD_NOP;
            cke   <= 1'b1;
            dqm   <= 2'b11;
            ba    <= 1'b0;
            addr  <= '0;
            ready <= 1'b0;
        end else begin
            {cs_n, ras_n, cas_n, we_n} <= cmd_sel;
            cke   <= 1'b1;
            dqm   <= 2'b11;
            ba    <= 1'b0;
            addr  <= addr_d;
            ready <= done;
        end
    end

endmodule

// File: rtl/sdram_init_seq.sv
// Module: top of the power-up sequencer.
// Puts the timer, the phase machine and the pin stage together. All delays
// are cycle counts of at least 2; REFRESH_COUNT must be 8 or more.
module sdram_init_seq
    import sdram_init_pkg::*;
#(
    parameter int WAIT_CYCLES      = 125000,
    parameter int TRP_CYCLES       = 8,
    parameter int TRC_CYCLES       = 23,
    parameter int TRSC_CYCLES      = 2,
    parameter int REFRESH_COUNT    = 8,
    parameter int BURST_LEN_CODE   = 3,
    parameter int BURST_INTERLEAVE = 0,
    parameter int CAS_LAT_CODE     = 2,
    parameter int OP_MODE_CODE     = 0
) (
    input  logic       clk,
    input  logic       rst_n,
    output logic       cke,
    output logic       cs_n,
    output logic       ras_n,
    output logic       cas_n,
    output logic       we_n,
    output logic [1:0] dqm,
    output logic       ba,
    output logic [8:0] addr,
    output logic       ready
);
    localparam int MAX_GAP = imax(imax(WAIT_CYCLES, TRP_CYCLES), imax(TRC_CYCLES, TRSC_CYCLES));
    localparam int TW      = $clog2(MAX_GAP + 1);
    localparam int CW      = $clog2(REFRESH_COUNT + 1);
    localparam logic [8:0] MODE_WORD = pack_mode(3'(BURST_LEN_CODE), 1'(BURST_INTERLEAVE),
                                                 3'(CAS_LAT_CODE), 2'(OP_MODE_CODE));

    logic          expired;
    logic          tmr_load;
    logic [TW-1:0] tmr_val;
    cmd_t          cmd_sel;
    logic          done;

    sdram_init_timer #(
        .WIDTH   (TW),
        .RST_VAL (WAIT_CYCLES - 1)
    ) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (expired)
    );

    sdram_init_ctrl #(
        .TW            (TW),
        .CW            (CW),
        .TRP_CYCLES    (TRP_CYCLES),
        .TRC_CYCLES    (TRC_CYCLES),
        .TRSC_CYCLES   (TRSC_CYCLES),
        .REFRESH_COUNT (REFRESH_COUNT)
    ) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .expired  (expired),
        .tmr_load (tmr_load),
        .tmr_val  (tmr_val),
        .cmd_sel  (cmd_sel),
        .done     (done)
    );

    sdram_cmd_drv u_drv (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_sel   (cmd_sel),
        .done      (done),
        .mode_word (MODE_WORD),
        .cke       (cke),
        .cs_n      (cs_n),
        .ras_n     (ras_n),
        .cas_n     (cas_n),
        .we_n      (we_n),
        .dqm       (dqm),
        .ba        (ba),
        .addr      (addr),
        .ready     (ready)
    );

endmodule

// File: rtl/sdram_init_chk.sv
// Module: protocol checker bound to the sequencer top.
// Watches only the pins. It measures the gaps between commands and counts
// refreshes with its own counters.
module sdram_init_chk #(
    parameter int TRP_CYCLES       = 8,
    parameter int TRC_CYCLES       = 23,
    parameter int TRSC_CYCLES      = 2,
    parameter int REFRESH_COUNT    = 8,
    parameter int BURST_LEN_CODE   = 3,
    parameter int BURST_INTERLEAVE = 0,
    parameter int CAS_LAT_CODE     = 2,
    parameter int OP_MODE_CODE     = 0
) (
    input logic       clk,
    input logic       rst_n,
    input logic       cke,
    input logic       cs_n,
    input logic       ras_n,
    input logic       cas_n,
    input logic       we_n,
    input logic [1:0] dqm,
    input logic       ba,
    input logic [8:0] addr,
    input logic       ready
);
    localparam logic [8:0] EXP_WORD = 9'(BURST_LEN_CODE + 8 * BURST_INTERLEAVE
                                         + 16 * CAS_LAT_CODE + 128 * OP_MODE_CODE);

    logic [3:0]  bus;
    logic        is_nop, is_pre, is_ref, is_mrs;
    logic        last_pre_q;
    logic [15:0] gap_q;
    logic [15:0] refs_q;

    // Pin decode.
    always_comb begin
        bus    = {cs_n, ras_n, cas_n, we_n};
        is_nop = (bus == 4'b0111);
        is_pre = (bus == 4'b0010);
        is_ref = (bus == 4'b0001);
        is_mrs = (bus == 4'b0000);
    end

    // Gap counter: cycles since the previous command, saturating.
    always_ff @(posedge clk) begin
        if (!rst_n)                     gap_q <= 16'hFFFF;
        else if (!is_nop)               gap_q <= 16'd1;
        else if (gap_q != 16'hFFFF)     gap_q <= gap_q + 16'd1;
    end

    // Kind of the previous command and the refresh tally.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            last_pre_q <= 1'b0;
            refs_q     <= '0;
        end else begin
            if (!is_nop) last_pre_q <= is_pre;
            if (is_ref)  refs_q <= refs_q + 16'd1;
        end
    end

    // R1
    reset_state_chk: assert property (@(posedge clk) !rst_n |=> (!ready && is_nop && cke && dqm == 2'b11));
    // R2
    pre_all_flag_chk: assert property (@(posedge clk) disable iff (!rst_n) is_pre |-> (addr[8] && !ba && refs_q == 16'd0));
    // R3
    trp_gap_chk: assert property (@(posedge clk) disable iff (!rst_n) (is_ref && last_pre_q) |-> gap_q == 16'(TRP_CYCLES));
    // R4
    trc_gap_chk: assert property (@(posedge clk) disable iff (!rst_n) (is_ref && !last_pre_q) |-> (refs_q != 16'd0 && gap_q == 16'(TRC_CYCLES)));
    // R4
    refresh_total_chk: assert property (@(posedge clk) disable iff (!rst_n) is_mrs |-> refs_q == 16'(REFRESH_COUNT));
    // R5
    mode_word_chk: assert property (@(posedge clk) disable iff (!rst_n) is_mrs |-> (addr == EXP_WORD && !ba && gap_q == 16'(TRC_CYCLES)));
    // R6
    ready_rise_chk: assert property (@(posedge clk) disable iff (!rst_n) $rose(ready) |-> gap_q == 16'(TRSC_CYCLES));
    // R6
    ready_hold_chk: assert property (@(posedge clk) disable iff (!rst_n) ready |=> (ready && is_nop));
    // R7
    pins_legal_chk: assert property (@(posedge clk) disable iff (!rst_n) (cke && dqm == 2'b11 && (is_nop || is_pre || is_ref || is_mrs)));
    // R7
    nop_after_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n) !is_nop |=> is_nop);

endmodule

bind sdram_init_seq sdram_init_chk #(
    .TRP_CYCLES       (TRP_CYCLES),
    .TRC_CYCLES       (TRC_CYCLES),
    .TRSC_CYCLES      (TRSC_CYCLES),
    .REFRESH_COUNT    (REFRESH_COUNT),
    .BURST_LEN_CODE   (BURST_LEN_CODE),
    .BURST_INTERLEAVE (BURST_INTERLEAVE),
    .CAS_LAT_CODE     (CAS_LAT_CODE),
    .OP_MODE_CODE     (OP_MODE_CODE)
) u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .cke   (cke),
    .cs_n  (cs_n),
    .ras_n (ras_n),
    .cas_n (cas_n),
    .we_n  (we_n),
    .dqm   (dqm),
    .ba    (ba),
    .addr  (addr),
    .ready (ready)
);

// File: tb/sdram_init_seq_test.sv
// Bench: runs a small configuration to completion and aborts it twice with
// reset. Every command's position is checked against arithmetic expectations.
module sdram_init_seq_test;

    localparam int WAIT  = 20;
    localparam int TRP   = 3;
    localparam int TRC   = 5;
    localparam int TRSC  = 4;
    localparam int NREF  = 9;
    localparam int BL    = 3;
    localparam int BT    = 1;
    localparam int CL    = 2;
    localparam int OP    = 0;
    localparam int MWORD = BL + 8 * BT + 16 * CL + 128 * OP;

    localparam logic [3:0] C_NOP = 4'b0111;
    localparam logic [3:0] C_PRE = 4'b0010;
    localparam logic [3:0] C_REF = 4'b0001;
    localparam logic [3:0] C_MRS = 4'b0000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cke, cs_n, ras_n, cas_n, we_n, ba, ready;
    logic [1:0] dqm;
    logic [8:0] addr;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;

    sdram_init_seq #(
        .WAIT_CYCLES      (WAIT),
        .TRP_CYCLES       (TRP),
        .TRC_CYCLES       (TRC),
        .TRSC_CYCLES      (TRSC),
        .REFRESH_COUNT    (NREF),
        .BURST_LEN_CODE   (BL),
        .BURST_INTERLEAVE (BT),
        .CAS_LAT_CODE     (CL),
        .OP_MODE_CODE     (OP)
    ) uut (
        .clk   (clk),
        .rst_n (rst_n),
        .cke   (cke),
        .cs_n  (cs_n),
        .ras_n (ras_n),
        .cas_n (cas_n),
        .we_n  (we_n),
        .dqm   (dqm),
        .ba    (ba),
        .addr  (addr),
        .ready (ready)
    );

    // 250 MHz clock.
    always #2 clk = ~clk;

    // Watchdog: a hung run counts as a failure and still prints the summary.
    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000) begin
            fails++;
            $display("FAIL watchdog R6: cycles %0d, expected completion", cyc);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d (t=%0t)", tag, act, exp, $time);
        end
    endtask

    // Hold reset two cycles and check the reset state (R1, R8).
    task automatic apply_reset();
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        chk({cs_n, ras_n, cas_n, we_n} === C_NOP, "R1 cmd", {cs_n, ras_n, cas_n, we_n}, C_NOP);
        chk(ready === 1'b0, "R1 ready", ready, 0);
        chk(cke === 1'b1 && dqm === 2'b11, "R1 cke/dqm", {cke, dqm}, 7);
        chk(ba === 1'b0 && addr === 9'd0, "R1 addr", addr, 0);
        @(negedge clk);
    endtask

    // Release reset and follow the sequence; abort_at >= 0 stops at that sample.
    task automatic run_seq(input int abort_at);
        int   idx    = 0;
        int   last   = -1;
        int   refs   = 0;
        int   mrs_at = -1;
        int   rdy_at = -1;
        bit   pre_seen = 0;
        logic [3:0] c;
        rst_n = 1'b1;
        while (1) begin
            c = {cs_n, ras_n, cas_n, we_n};
            if (idx == abort_at) break;
            chk(cke === 1'b1 && dqm === 2'b11, "R7 cke/dqm", {cke, dqm}, 7);
            case (c)
                C_NOP: ;
                C_PRE: begin
                    chk(!pre_seen && idx == WAIT, "R2 precharge time", idx, WAIT);
                    chk(addr[8] === 1'b1 && ba === 1'b0, "R2 precharge-all flag", addr, 256);
                    pre_seen = 1;
                    last = idx;
                end
                C_REF: begin
                    if (refs == 0) chk(pre_seen && idx - last == TRP, "R3 tRP gap", idx - last, TRP);
                    else           chk(idx - last == TRC, "R4 tRC gap", idx - last, TRC);
                    refs++;
                    last = idx;
                end
                C_MRS: begin
                    chk(refs == NREF, "R4 refresh total", refs, NREF);
                    chk(idx - last == TRC, "R5 gap to mode load", idx - last, TRC);
                    chk(addr === 9'(MWORD) && ba === 1'b0, "R5 mode word", addr, MWORD);
                    mrs_at = idx;
                    last = idx;
                end
                default: chk(0, "R7 illegal command", c, C_NOP);
            endcase
            if (rdy_at < 0 && ready === 1'b1) begin
                chk(mrs_at >= 0 && idx - mrs_at == TRSC, "R6 ready delay", idx - mrs_at, TRSC);
                rdy_at = idx;
            end else if (rdy_at >= 0) begin
                chk(ready === 1'b1 && c == C_NOP, "R6 ready hold", {ready, c}, {1'b1, C_NOP});
            end else begin
                chk(ready === 1'b0, "R6 ready early", ready, 0);
            end
            if (rdy_at >= 0 && idx >= rdy_at + 6) break;
            if (idx > 2000) begin
                chk(0, "R6 never ready", idx, 0);
                break;
            end
            @(negedge clk);
            idx++;
        end
        if (abort_at < 0) chk(rdy_at >= 0 && refs == NREF, "R4 full run", refs, NREF);
    endtask

    initial begin
        repeat (2) @(posedge clk);
        apply_reset();
        run_seq(-1);
        // R8: abort during the start-up wait, then during the refresh loop.
        apply_reset();
        run_seq(10);
        apply_reset();
        run_seq(WAIT + TRP + 2 * TRC + 1);
        apply_reset();
        run_seq(-1);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule